// File: doc/BRIEF.md
# Parallel Port Extended Control Register with Transmit FIFO

This block is the extended control register of a parallel port that can run in several signalling modes, together with the 16-byte transmit FIFO that the register reports on. A host reaches two locations through a small synchronous bus with an address, a write strobe, a read strobe and byte-wide data. One location pushes bytes into the FIFO. The other holds the control register. A 3-bit mode field in the top three bits of that register selects the port's behaviour. The two lowest bits show live FIFO status: full and empty.

Driver software uses the register in two ways. It writes a mode value and reads it back, and a matching readback shows that the register exists. It also polls the empty bit to learn whether queued bytes have left the port. The FIFO drains toward the peripheral only in the FIFO mode (mode 011). In that mode each acknowledge pulse from the peripheral retires one byte. In every other mode the queued bytes stay put.

Top module: `ecp_ext_ctrl`

## Requirements
- R1: After a write to the control offset (address 2), a read of that offset returns bits 7:5 equal to bits 7:5 of the written byte.
- R2: Writing 0x20 to the control offset sets mode 001 (bidirectional byte mode). With the FIFO empty, the register then reads 0x21.
- R3: Writing 0x80 sets mode 100 (enhanced address/data mode). The register then reads 0x80 while the FIFO holds data.
- R4: Writing 0x70 sets mode 011 (FIFO mode). In that mode the FIFO retires exactly one byte for each rising edge of `per_ack`. An acknowledge held high retires only one byte.
- R5: Bit 0 of the control register reads 1 when the FIFO is empty and 0 while any byte remains.
- R6: Bit 1 of the control register reads 1 when the FIFO holds 16 bytes and 0 otherwise.
- R7: A write to the FIFO offset (address 0) appends the byte. A write while the FIFO is full is discarded and sets `fifo_overrun`, which stays set until reset. This holds even when a byte is retired in the same cycle.
- R8: In any mode other than 011, acknowledge pulses retire nothing, the queued bytes are kept and `per_valid` stays 0.
- R9: After reset the mode field is 000, the FIFO is empty, the control register reads 0x01, `fifo_overrun` is 0 and `per_valid` is 0.
- R10: Bits 4:2 of a control write are stored and read back unchanged, with no effect on behaviour. Bits 1:0 of a control write are ignored, and the status bits are read in their place.
- R11: `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value otherwise. A read of any offset other than the control offset returns 0x00.
- R12: The FIFO releases bytes in write order. `per_data` shows the oldest byte while `per_valid` is 1 and shows 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Host offset: 0 is the FIFO data, 2 is the control register |
| bus_wr | input | 1 | Host write strobe, one byte per cycle |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| per_ack | input | 1 | Peripheral acknowledge; each rising edge retires one byte in mode 011 |
| per_data | output | 8 | Oldest queued byte presented to the peripheral |
| per_valid | output | 1 | A byte is presented (mode 011 and FIFO not empty) |
| fifo_overrun | output | 1 | Sticky flag: a push was made while the FIFO was full |

## Verification
The hardest state to reach is a full FIFO that receives a push and an acknowledge edge in the same cycle. The stimulus gets there in two steps. It first fills all 16 entries in mode 000, where nothing drains, and confirms the full bit and the overrun flag. It then switches to mode 011 and issues the push and the acknowledge edge together. This shows that the extra byte is dropped even though a slot frees in that cycle. The drain that follows checks that neither discarded byte appears in the write-ordered output. An acknowledge held high for several cycles checks the one-byte-per-pulse rule.

// File: rtl/ecp_ecr_pkg.sv
`timescale 1ns/1ps
package ecp_ecr_pkg;

  localparam int unsigned ECR_W = 8;

  typedef enum logic [2:0] {
    MODE_STD      = 3'b000,
    MODE_BIDIR    = 3'b001,
    MODE_FAST_SPP = 3'b010,
    MODE_FIFO     = 3'b011,
    MODE_ADDRDATA = 3'b100,
    MODE_RSV5     = 3'b101,
    MODE_TEST     = 3'b110,
    MODE_CONFIG   = 3'b111
  } ecr_mode_e;

  typedef struct packed {
    ecr_mode_e  mode;
    logic [2:0] spare;
  } ecr_cfg_t;

  // Builds the readback byte: mode, spare bits, full, empty.
  function automatic logic [ECR_W-1:0] ecr_pack(input ecr_cfg_t cfg,
                                                input logic full,
                                                input logic empty);
    return {cfg.mode, cfg.spare, full, empty};
  endfunction

  // Takes the writable upper six bits of a control write.
  function automatic ecr_cfg_t ecr_unpack(input logic [5:0] hi);
    ecr_cfg_t c;
    c.mode  = ecr_mode_e'(hi[5:3]);
    c.spare = hi[2:0];
    return c;
  endfunction

  // Only the FIFO mode retires bytes toward the peripheral.
  function automatic logic mode_drains(input ecr_mode_e m);
    return m == MODE_FIFO;
  endfunction

endpackage

// File: rtl/ecp_bus_decode.sv
`timescale 1ns/1ps
module ecp_bus_decode #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned FIFO_OFS = 0,
  parameter int unsigned CTRL_OFS = 2
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              fifo_wr,
  output logic              ctrl_wr,
  output logic              ctrl_rd,
  output logic              any_rd
);
  localparam logic [ADDR_W-1:0] FIFO_A = ADDR_W'(FIFO_OFS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  logic hit_fifo;
  logic hit_ctrl;

  assign hit_fifo = (bus_addr == FIFO_A);
  assign hit_ctrl = (bus_addr == CTRL_A);

  assign fifo_wr = bus_wr & hit_fifo;
  assign ctrl_wr = bus_wr & hit_ctrl;
  assign ctrl_rd = bus_rd & hit_ctrl;
  assign any_rd  = bus_rd;
endmodule

// File: rtl/ecp_ctrl_reg.sv
`timescale 1ns/1ps
module ecp_ctrl_reg
  import ecp_ecr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_rd,
  input  logic             any_rd,
  input  logic [5:0]       wdata_hi,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  output ecr_cfg_t         cfg,
  output logic [ECR_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '{mode: MODE_STD, spare: 3'b000};
    end else if (ctrl_wr) begin
      cfg <= ecr_unpack(wdata_hi);
    end
  end

  // The status bits are sampled live at the read edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (any_rd) begin
      rdata <= ctrl_rd ? ecr_pack(cfg, fifo_full, fifo_empty) : '0;
    end
  end
endmodule

// File: rtl/ecp_ack_edge.sv
`timescale 1ns/1ps
module ecp_ack_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic rise
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack;
  end

  assign rise = ack & ~ack_q;
endmodule

// File: rtl/ecp_byte_fifo.sv
`timescale 1ns/1ps
module ecp_byte_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              pop_ok,
  output logic              overrun
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_ptr;
  logic              push_ok;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  // Fullness is judged before this cycle's pop, so a push into a full FIFO drops.
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (push_req & full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ecp_ext_ctrl.sv
`timescale 1ns/1ps
module ecp_ext_ctrl
  import ecp_ecr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned FIFO_OFS = 0,
  parameter int unsigned CTRL_OFS = 2,
  parameter int unsigned DEPTH    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ECR_W-1:0]  bus_wdata,
  output logic [ECR_W-1:0]  bus_rdata,
  input  logic              per_ack,
  output logic [ECR_W-1:0]  per_data,
  output logic              per_valid,
  output logic              fifo_overrun
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic             push_req;
  logic             ctrl_wr;
  logic             ctrl_rd;
  logic             any_rd;
  logic             ack_rise;
  logic             pop_req;
  logic             pop_evt;
  logic [CNT_W-1:0] fifo_count;
  logic             fifo_full;
  logic             fifo_empty;
  logic [ECR_W-1:0] fifo_head;
  ecr_cfg_t         cfg;
  logic [2:0]       cur_mode;

  ecp_bus_decode #(
    .ADDR_W  (ADDR_W),
    .FIFO_OFS(FIFO_OFS),
    .CTRL_OFS(CTRL_OFS)
  ) u_decode (
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .fifo_wr (push_req),
    .ctrl_wr (ctrl_wr),
    .ctrl_rd (ctrl_rd),
    .any_rd  (any_rd)
  );

  ecp_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_rd   (ctrl_rd),
    .any_rd    (any_rd),
    .wdata_hi  (bus_wdata[7:2]),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .cfg       (cfg),
    .rdata     (bus_rdata)
  );

  ecp_ack_edge u_ack (
    .clk  (clk),
    .rst_n(rst_n),
    .ack  (per_ack),
    .rise (ack_rise)
  );

  assign cur_mode = cfg.mode;
  assign pop_req  = ack_rise & mode_drains(cfg.mode);

  ecp_byte_fifo #(
    .DATA_W(ECR_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .push_data(bus_wdata),
    .pop_req  (pop_req),
    .head     (fifo_head),
    .count    (fifo_count),
    .full     (fifo_full),
    .empty    (fifo_empty),
    .pop_ok   (pop_evt),
    .overrun  (fifo_overrun)
  );

  assign per_valid = ~fifo_empty & mode_drains(cfg.mode);
  assign per_data  = per_valid ? fifo_head : '0;
endmodule

// File: rtl/ecp_ext_ctrl_chk.sv
`timescale 1ns/1ps
module ecp_ext_ctrl_chk #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned CTRL_OFS = 2,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned CNT_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [2:0]        cur_mode,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              push_req,
  input logic              pop_evt,
  input logic              fifo_overrun
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  a_r1_mode_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_A) |=> (cur_mode == $past(bus_wdata[7:5])));

  a_r5_empty_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTRL_A) |=> (bus_rdata[0] == $past(fifo_count == '0)));

  a_r6_full_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTRL_A) |=> (bus_rdata[1] == $past(fifo_count == CNT_W'(DEPTH))));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overrun |=> fifo_overrun);

  a_r7_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_count == CNT_W'(DEPTH)) |=> (fifo_overrun && fifo_count <= $past(fifo_count)));

  a_r8_no_drain_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != 3'b011) |=> (fifo_count >= $past(fifo_count)));

  a_r4_one_pop_per_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> !pop_evt);
endmodule

bind ecp_ext_ctrl ecp_ext_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .CTRL_OFS(CTRL_OFS),
  .DEPTH   (DEPTH),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .cur_mode    (cur_mode),
  .fifo_count  (fifo_count),
  .push_req    (push_req),
  .pop_evt     (pop_evt),
  .fifo_overrun(fifo_overrun)
);

// File: tb/test_ecp_ext_ctrl.sv
`timescale 1ns/1ps
module test_ecp_ext_ctrl;
  localparam int DEPTH = 16;
  localparam int FOFS  = 0;
  localparam int COFS  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       per_ack = 1'b0;
  wire  [7:0] bus_rdata;
  wire  [7:0] per_data;
  wire        per_valid;
  wire        fifo_overrun;

  always #2 clk = ~clk;

  ecp_ext_ctrl i_ecp_ext_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .per_ack(per_ack), .per_data(per_data), .per_valid(per_valid),
    .fifo_overrun(fifo_overrun)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R9";
  bit    ack_lvl = 1'b0;
  bit    done = 1'b0;

  // Behavioural reference state
  int           m_mode, m_spare, m_rdata;
  byte unsigned m_q[$];
  bit           m_ovf, m_ack_prev;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_ctrl();
    return (m_mode << 5) | (m_spare << 2) | (int'(m_q.size() == DEPTH) << 1)
           | int'(m_q.size() == 0);
  endfunction

  function automatic void m_reset();
    m_mode = 0; m_spare = 0; m_rdata = 0; m_q.delete(); m_ovf = 0; m_ack_prev = 0;
  endfunction

  function automatic void m_step(int a, bit w, bit r, int d, bit ack);
    int  ctrl_now = m_ctrl();
    bit  full_now = (m_q.size() == DEPTH);
    bit  rise = ack && !m_ack_prev;
    if (r) m_rdata = (a == COFS) ? ctrl_now : 0;
    if (rise && m_mode == 3 && m_q.size() > 0) void'(m_q.pop_front());
    if (w && a == FOFS) begin
      if (full_now) m_ovf = 1;
      else m_q.push_back(byte'(d));
    end
    if (w && a == COFS) begin
      m_mode = (d >> 5) & 7;
      m_spare = (d >> 2) & 7;
    end
    m_ack_prev = ack;
  endfunction

  task automatic compare();
    bit v = (m_mode == 3) && (m_q.size() > 0);
    chk(cur_req, "bus_rdata", int'(bus_rdata), m_rdata);
    chk(cur_req, "per_valid", int'(per_valid), int'(v));
    chk(cur_req, "per_data", int'(per_data), v ? int'(m_q[0]) : 0);
    chk(cur_req, "fifo_overrun", int'(fifo_overrun), int'(m_ovf));
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(int a, bit w, bit r, int d);
    bus_addr = 3'(a); bus_wr = w; bus_rd = r; bus_wdata = 8'(d); per_ack = ack_lvl;
    @(posedge clk);
    m_step(a, w, r, d, ack_lvl);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    compare();
  endtask

  task automatic idle();            step(0, 0, 0, 0); endtask
  task automatic wr(int a, int d);  step(a, 1, 0, d); endtask
  task automatic rd_ctrl(string req, int exp);
    step(COFS, 0, 1, 0);
    chk(req, "control readback", int'(bus_rdata), exp);
  endtask
  task automatic pulse();
    ack_lvl = 1'b1; idle();
    ack_lvl = 1'b0; idle();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();
    // R9 reset state
    rd_ctrl("R9", 8'h01);
    chk("R9", "per_valid", int'(per_valid), 0);
    chk("R9", "fifo_overrun", int'(fifo_overrun), 0);

    // R2 bidirectional mode; R8 no drain there
    cur_req = "R2";
    wr(COFS, 8'h20);
    rd_ctrl("R2", 8'h21);
    cur_req = "R8";
    wr(FOFS, 8'hA1); wr(FOFS, 8'hA2); wr(FOFS, 8'hA3);
    pulse(); pulse();
    rd_ctrl("R5", 8'h20);
    chk("R8", "per_valid outside FIFO mode", int'(per_valid), 0);

    // R3 and R10: bits 1:0 of the write ignored
    cur_req = "R3";
    wr(COFS, 8'h83);
    rd_ctrl("R3", 8'h80);
    cur_req = "R10";
    wr(COFS, 8'h9C);
    rd_ctrl("R10", 8'h9C);
    pulse();
    rd_ctrl("R10", 8'h9C);

    // R11 other offsets read zero, readback holds without strobe
    cur_req = "R11";
    rd_ctrl("R1", 8'h9C);
    idle(); idle();
    chk("R11", "rdata holds", int'(bus_rdata), 8'h9C);
    step(FOFS, 0, 1, 0);
    chk("R11", "fifo offset read", int'(bus_rdata), 0);
    step(5, 0, 1, 0);
    chk("R11", "unused offset read", int'(bus_rdata), 0);

    // R4 FIFO mode drains, R12 in order
    cur_req = "R4";
    wr(COFS, 8'h70);
    chk("R12", "head byte", int'(per_data), 8'hA1);
    rd_ctrl("R4", 8'h70);
    ack_lvl = 1'b1; idle();
    chk("R4", "first pop", int'(per_data), 8'hA2);
    idle(); idle(); idle();
    chk("R4", "held ack pops once", int'(per_data), 8'hA2);
    ack_lvl = 1'b0; idle();
    pulse();
    chk("R12", "third byte", int'(per_data), 8'hA3);
    pulse();
    chk("R4", "drained valid", int'(per_valid), 0);
    rd_ctrl("R5", 8'h71);
    pulse();

    // R6 fill to full in a non-draining mode, R7 overrun
    cur_req = "R6";
    wr(COFS, 8'h00);
    for (int i = 0; i < DEPTH; i++) wr(FOFS, i * 7 + 3);
    rd_ctrl("R6", 8'h02);
    chk("R7", "no overrun yet", int'(fifo_overrun), 0);
    cur_req = "R7";
    wr(FOFS, 8'hEE);
    chk("R7", "overrun set", int'(fifo_overrun), 1);
    wr(COFS, 8'h70);
    rd_ctrl("R6", 8'h72);
    // push and acknowledge edge together while full: pop happens, push dropped
    ack_lvl = 1'b1; wr(FOFS, 8'hCC);
    ack_lvl = 1'b0; idle();
    chk("R7", "drop despite pop", int'(per_data), 10);
    rd_ctrl("R6", 8'h70);
    cur_req = "R12";
    for (int i = 1; i < DEPTH; i++) begin
      chk("R12", "drain order", int'(per_data), i * 7 + 3);
      pulse();
    end
    rd_ctrl("R5", 8'h71);
    chk("R7", "overrun sticky", int'(fifo_overrun), 1);

    // R12 push and pop in the same cycle
    wr(FOFS, 8'h11);
    ack_lvl = 1'b1; wr(FOFS, 8'h22);
    ack_lvl = 1'b0; idle();
    chk("R12", "same-cycle push/pop", int'(per_data), 8'h22);

    // R9 reset clears the sticky flag and the mode
    cur_req = "R9";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_reset();
    compare();
    chk("R9", "overrun after reset", int'(fifo_overrun), 0);
    rd_ctrl("R9", 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule